// File: doc/BRIEF.md
# Oversampled Serial Receive Engine

This block recovers asynchronous serial characters from a single receive line. It is paced by a clock enable that pulses sixteen times per bit period. A falling line starts a character. The engine confirms the start bit near its middle. It then decides every following bit from three consecutive samples taken around mid-bit and shifts the data in least significant bit first.

Each finished character leaves the block as one parallel word, valid for a single cycle. The word carries three status flags: framing, parity and noise. Configuration inputs select the word length (8 or 9 bits), whether a parity bit is present, its sense (even or odd) and whether one or two stop bits are expected. The configuration is captured when a start bit is detected.

A line held low is closed out as a single all-zero character with a framing error. The engine then waits for the line to go high before it looks for another start bit. An idle output reports when no character is in progress. Baud-rate generation, character buffering and any register interface belong to the surrounding logic.

Top module: `uart_os_rx`

## Requirements
- R1: After reset `rx_idle` is 1 and `out_valid` is 0.
- R2: Data bits follow the start bit least significant bit first. Each finished character appears on `out_data` with `out_valid` high.
- R3: With `cfg_nine`=1 the ninth received data bit appears on `out_bit8`. With `cfg_nine`=0 only 8 data bits are received and `out_bit8` is 0.
- R4: Each bit value is the majority of the three samples taken at sixteenth-ticks 7, 8 and 9 of the bit, counted from 0 at the tick where the start edge is first seen. A single disagreeing sample does not change the bit. `out_nerr` is 1 when any vote of the character, including the start and stop votes, was not unanimous.
- R5: With `cfg_par_en`=1 a parity bit follows the data. `out_perr` is 1 when the number of ones in data plus parity is odd while `cfg_par_odd`=0, or even while `cfg_par_odd`=1. With `cfg_par_en`=0, `out_perr` is 0.
- R6: `out_ferr` is 1 when any expected stop bit (one, or two with `cfg_two_stop`=1) votes low.
- R7: A start edge whose vote at ticks 7 to 9 is high is a glitch. No character is produced and the engine returns to idle.
- R8: A line held low for a long time yields exactly one character: all data zeros and `out_ferr`=1, finished at the normal frame length.
- R9: After a character with a framing error, no new start is accepted until the line has been seen high. Characters then resume normally.
- R10: `rx_idle` is 0 from the start detection until the final stop vote, and 1 from then on, including when `out_valid` is high.
- R11: While `rx_en`=0 the engine stays idle and produces no characters.
- R12: `out_valid` is high for exactly one clock per character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_two_stop | input | 1 | 1 expects two stop bits |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| out_valid | output | 1 | One-cycle pulse per finished character |
| out_data | output | 8 | Low data bits of the character |
| out_bit8 | output | 1 | Ninth data bit in 9-bit mode |
| out_ferr | output | 1 | Framing error of the character |
| out_perr | output | 1 | Parity error of the character |
| out_nerr | output | 1 | Noise seen in the character |
| rx_idle | output | 1 | No character in progress |

## Verification
The assertions assume two things about the inputs. First, `tick16` pulses no more often than every other clock. Second, the configuration inputs hold steady for the length of a character, so the captured settings describe what is on the output. The stimulus raises `tick16` for one clock in every four and changes the line only just after a tick, leaving room for the two-stage synchronizer. It changes the configuration only between characters, once the line has been high for two bit times. Noise is injected by inverting the line for exactly the tick that feeds the middle sample of a chosen bit.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP1,
    S_STOP2,
    S_HOLD
  } rx_state_e;

  typedef struct packed {
    logic nine;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } rx_cfg_t;

  // level decided by two of three samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // samples not all equal
  function automatic logic split3(input logic a, input logic b, input logic c);
    return !((a == b) && (b == c));
  endfunction

  // parity mismatch from the data reduction, the received bit and the sense
  function automatic logic par_bad(input logic data_xor, input logic pbit, input logic odd);
    return data_xor ^ pbit ^ odd;
  endfunction

endpackage

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= RST_VAL;
        else        sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/uart_os_rx_vote.sv
module uart_os_rx_vote
  import uart_os_rx_pkg::*;
#(
  parameter int OS   = 16,
  parameter int MID  = 8,
  parameter int PH_W = $clog2(OS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            active,
  input  logic [PH_W-1:0] phase,
  input  logic            rx_s,
  output logic            vote_stb,
  output logic            vote_val,
  output logic            vote_noisy
);
  localparam logic [PH_W-1:0] PH_EARLY = PH_W'(MID - 1);
  localparam logic [PH_W-1:0] PH_MID   = PH_W'(MID);
  localparam logic [PH_W-1:0] PH_LATE  = PH_W'(MID + 1);

  logic s_early, s_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_early <= 1'b1;
      s_mid   <= 1'b1;
    end else if (tick && active) begin
      if (phase == PH_EARLY) s_early <= rx_s;
      if (phase == PH_MID)   s_mid   <= rx_s;
    end
  end

  // third sample is the live line at the late phase
  assign vote_stb   = tick && active && (phase == PH_LATE);
  assign vote_val   = vote3(s_early, s_mid, rx_s);
  assign vote_noisy = split3(s_early, s_mid, rx_s);
endmodule

// File: rtl/uart_os_rx_fsm.sv
module uart_os_rx_fsm
  import uart_os_rx_pkg::*;
#(
  parameter int OS     = 16,
  parameter int BASE_W = 8,
  parameter int WORD_W = BASE_W + 1,
  parameter int PH_W   = $clog2(OS),
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              tick,
  input  logic              rx_s,
  input  rx_cfg_t           cfg,
  input  logic              vote_stb,
  input  logic              vote_val,
  input  logic              vote_noisy,
  output logic [PH_W-1:0]   phase,
  output logic              active,
  output logic              idle,
  output logic              ev_start,
  output logic              ev_glitch,
  output logic              ev_done,
  output logic [WORD_W-1:0] res_word,
  output logic              res_ferr,
  output logic              res_perr,
  output logic              res_nerr,
  output rx_cfg_t           cfg_q
);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(OS - 1);
  localparam logic [IDX_W-1:0] IDX_LONG = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] IDX_BASE = IDX_W'(BASE_W - 1);

  rx_state_e         state;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word;
  logic              pbit, ferr_a, nerr_a;

  logic             bit_end, final_stop;
  logic [IDX_W-1:0] last_idx;

  assign last_idx   = cfg_q.nine ? IDX_LONG : IDX_BASE;
  assign bit_end    = tick && (phase == PH_LAST);
  assign active     = (state != S_IDLE) && (state != S_HOLD);
  assign idle       = !active;
  assign final_stop = (state == S_STOP2) || ((state == S_STOP1) && !cfg_q.two_stop);

  assign ev_start  = rx_en && tick && (state == S_IDLE) && !rx_s;
  assign ev_glitch = rx_en && vote_stb && (state == S_START) && vote_val;
  assign ev_done   = rx_en && vote_stb && final_stop;

  // result of the character, valid together with ev_done
  assign res_word = cfg_q.nine ? word : {1'b0, word[BASE_W-1:0]};
  assign res_ferr = ferr_a | !vote_val;
  assign res_nerr = nerr_a | vote_noisy;
  assign res_perr = cfg_q.par_en & par_bad(^res_word, pbit, cfg_q.par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      phase  <= '0;
      idx    <= '0;
      word   <= '0;
      pbit   <= 1'b0;
      ferr_a <= 1'b0;
      nerr_a <= 1'b0;
      cfg_q  <= '0;
    end else if (!rx_en) begin
      state <= S_IDLE;
      phase <= '0;
    end else if (tick) begin
      case (state)
        S_IDLE: begin
          if (!rx_s) begin
            state  <= S_START;
            phase  <= PH_W'(1);
            idx    <= '0;
            word   <= '0;
            pbit   <= 1'b0;
            ferr_a <= 1'b0;
            nerr_a <= 1'b0;
            cfg_q  <= cfg;
          end
        end
        S_HOLD: begin
          if (rx_s) state <= S_IDLE;
        end
        default: begin
          phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
          if (vote_stb) nerr_a <= nerr_a | vote_noisy;
          case (state)
            S_START: begin
              if (vote_stb && vote_val) begin
                state <= S_IDLE;
                phase <= '0;
              end else if (bit_end) begin
                state <= S_DATA;
              end
            end
            S_DATA: begin
              if (vote_stb) word[idx] <= vote_val;
              if (bit_end) begin
                if (idx == last_idx) state <= cfg_q.par_en ? S_PAR : S_STOP1;
                else                 idx   <= idx + 1'b1;
              end
            end
            S_PAR: begin
              if (vote_stb) pbit <= vote_val;
              if (bit_end) state <= S_STOP1;
            end
            S_STOP1, S_STOP2: begin
              if (vote_stb) begin
                if (final_stop) begin
                  state <= res_ferr ? S_HOLD : S_IDLE;
                  phase <= '0;
                end else begin
                  ferr_a <= ferr_a | !vote_val;
                end
              end else if (bit_end && (state == S_STOP1)) begin
                state <= S_STOP2;
              end
            end
            default: state <= S_IDLE;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_os_rx_pkg::*;
#(
  parameter int OS          = 16,
  parameter int MID         = OS / 2,
  parameter int BASE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              tick16,
  input  logic              cfg_nine,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              rx_line,
  output logic              out_valid,
  output logic [BASE_W-1:0] out_data,
  output logic              out_bit8,
  output logic              out_ferr,
  output logic              out_perr,
  output logic              out_nerr,
  output logic              rx_idle
);
  localparam int WORD_W = BASE_W + 1;
  localparam int PH_W   = $clog2(OS);

  logic              rx_s;
  logic [PH_W-1:0]   phase;
  logic              active;
  logic              vote_stb, vote_val, vote_noisy;
  logic              ev_start, ev_glitch, ev_done;
  logic [WORD_W-1:0] res_word;
  logic              res_ferr, res_perr, res_nerr;
  logic              lat_nine, lat_par_en;
  rx_cfg_t           cfg_in, cfg_q;

  assign cfg_in = '{nine: cfg_nine, par_en: cfg_par_en, par_odd: cfg_par_odd, two_stop: cfg_two_stop};
  assign lat_nine   = cfg_q.nine;
  assign lat_par_en = cfg_q.par_en;

  uart_os_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_s)
  );

  uart_os_rx_vote #(.OS(OS), .MID(MID), .PH_W(PH_W)) u_vote (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .active(active), .phase(phase),
    .rx_s(rx_s), .vote_stb(vote_stb), .vote_val(vote_val), .vote_noisy(vote_noisy)
  );

  uart_os_rx_fsm #(.OS(OS), .BASE_W(BASE_W), .WORD_W(WORD_W), .PH_W(PH_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(tick16), .rx_s(rx_s), .cfg(cfg_in),
    .vote_stb(vote_stb), .vote_val(vote_val), .vote_noisy(vote_noisy),
    .phase(phase), .active(active), .idle(rx_idle),
    .ev_start(ev_start), .ev_glitch(ev_glitch), .ev_done(ev_done),
    .res_word(res_word), .res_ferr(res_ferr), .res_perr(res_perr), .res_nerr(res_nerr),
    .cfg_q(cfg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_bit8  <= 1'b0;
      out_ferr  <= 1'b0;
      out_perr  <= 1'b0;
      out_nerr  <= 1'b0;
    end else begin
      out_valid <= ev_done;
      if (ev_done) begin
        out_data <= res_word[BASE_W-1:0];
        out_bit8 <= res_word[BASE_W];
        out_ferr <= res_ferr;
        out_perr <= res_perr;
        out_nerr <= res_nerr;
      end
    end
  end
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic out_valid,
  input logic rx_idle,
  input logic out_bit8,
  input logic out_perr,
  input logic ev_start,
  input logic ev_glitch,
  input logic ev_done,
  input logic lat_nine,
  input logic lat_par_en
);
  assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_idle_with_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rx_idle);

  assert_busy_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !rx_idle);

  assert_glitch_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_glitch |=> rx_idle);

  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!out_valid && rx_idle));

  assert_short_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !lat_nine) |-> !out_bit8);

  assert_no_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !lat_par_en) |-> !out_perr);

  assert_events_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_start, ev_glitch, ev_done}));
endmodule

bind uart_os_rx uart_os_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .out_valid(out_valid), .rx_idle(rx_idle),
  .out_bit8(out_bit8), .out_perr(out_perr), .ev_start(ev_start), .ev_glitch(ev_glitch),
  .ev_done(ev_done), .lat_nine(lat_nine), .lat_par_en(lat_par_en)
);

// File: tb/uart_os_rx_test.sv
`timescale 1ns/1ps
module uart_os_rx_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, rx_en = 1'b1, tick16 = 1'b0, rx_line = 1'b1;
  logic       cfg_nine = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0;
  logic       out_valid, out_bit8, out_ferr, out_perr, out_nerr, rx_idle;
  logic [7:0] out_data;

  uart_os_rx uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick16(tick16), .cfg_nine(cfg_nine),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .rx_line(rx_line), .out_valid(out_valid), .out_data(out_data), .out_bit8(out_bit8),
    .out_ferr(out_ferr), .out_perr(out_perr), .out_nerr(out_nerr), .rx_idle(rx_idle)
  );

  int n_cmp = 0, n_bad = 0;
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv   = (tdiv + 1) % 4;
    tick16 = (tdiv == 0);
  end

  // result monitor
  int cap_cnt = 0, run = 0, max_run = 0;
  logic [7:0] cap_data;
  logic cap_b8, cap_fe, cap_pe, cap_ne;
  always @(negedge clk) begin
    if (out_valid) begin
      cap_cnt++;
      run++;
      if (run > max_run) max_run = run;
      cap_data = out_data; cap_b8 = out_bit8;
      cap_fe = out_ferr; cap_pe = out_perr; cap_ne = out_nerr;
    end else run = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick_wait();
    do @(posedge clk); while (!tick16);
    @(negedge clk);
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) tick_wait();
  endtask

  // frame index: 0 start, then data, optional parity, stops; nidx<0 means no noise
  task automatic send_frame(input logic nine, input logic pe, input logic po, input logic ts,
                            input logic [8:0] d, input int nidx, input logic fp,
                            input logic bs, input logic chk_idle);
    logic bits [0:13];
    int n, nb;
    nb = nine ? 9 : 8;
    bits[0] = 1'b0;
    for (int i = 0; i < nb; i++) bits[1+i] = d[i];
    n = 1 + nb;
    if (pe) begin
      bits[n] = (^(nine ? d : {1'b0, d[7:0]})) ^ po ^ fp;
      n++;
    end
    bits[n] = 1'b1; n++;
    if (ts) begin bits[n] = 1'b1; n++; end
    if (bs) bits[n-1] = 1'b0;
    for (int f = 0; f < n; f++) begin
      for (int t = 1; t <= 16; t++) begin
        if (chk_idle && f == 1 && t == 1) chk("R10 busy during frame", rx_idle, 1'b0);
        rx_line = (f == nidx && t == 9) ? ~bits[f] : bits[f];
        tick_wait();
      end
    end
    rx_line = 1'b1;
    ticks(32);
  endtask

  // {nine, par_en, par_odd, two_stop, data[8:0], noise_idx[3:0] (15 none), flip_par, bad_stop}
  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5, 4'hF,  1'b0, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 9'h03C, 4'd3,  1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b0, 9'h037, 4'hF,  1'b0, 1'b0},
    {1'b0, 1'b1, 1'b1, 1'b0, 9'h037, 4'hF,  1'b1, 1'b0},
    {1'b1, 1'b0, 1'b0, 1'b0, 9'h1C3, 4'hF,  1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b1, 9'h0FF, 4'hF,  1'b0, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b1, 9'h081, 4'hF,  1'b0, 1'b1},
    {1'b0, 1'b1, 1'b0, 1'b1, 9'h000, 4'd0,  1'b0, 1'b0},
    {1'b1, 1'b0, 1'b0, 1'b0, 9'h155, 4'd10, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b1, 1'b0, 9'h0C4, 4'd9,  1'b0, 1'b0}
  };

  bit done_flag = 0;

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 idle in reset", rx_idle, 1'b1);
    chk("R1 no valid in reset", out_valid, 1'b0);
    rst_n = 1'b1;
    ticks(4);
    chk("R1 idle after reset", rx_idle, 1'b1);
    chk("R1 no valid after reset", out_valid, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      int pre, nidx;
      v = VEC[i];
      cfg_nine = v[18]; cfg_par_en = v[17]; cfg_par_odd = v[16]; cfg_two_stop = v[15];
      nidx = (v[5:2] == 4'hF) ? -1 : int'(v[5:2]);
      pre = cap_cnt;
      send_frame(v[18], v[17], v[16], v[15], v[14:6], nidx, v[1], v[0], 1'b1);
      chk("R2 one character", cap_cnt, pre + 1);
      chk("R2 data", cap_data, v[13:6]);
      chk("R3 ninth bit", cap_b8, v[18] ? v[14] : 1'b0);
      chk("R5 parity flag", cap_pe, v[17] & v[1]);
      chk("R6 framing flag", cap_fe, v[0]);
      chk("R4 noise flag", cap_ne, (nidx >= 0));
      chk("R10 idle after frame", rx_idle, 1'b1);
    end

    // glitches on the start edge
    begin
      int pre;
      cfg_nine = 0; cfg_par_en = 0; cfg_par_odd = 0; cfg_two_stop = 0;
      pre = cap_cnt;
      rx_line = 1'b0; ticks(3); rx_line = 1'b1; ticks(32);
      chk("R7 short glitch no char", cap_cnt, pre);
      chk("R7 idle after glitch", rx_idle, 1'b1);
      rx_line = 1'b0; ticks(8); rx_line = 1'b1; ticks(32);
      chk("R7 edge glitch no char", cap_cnt, pre);
      send_frame(0, 0, 0, 0, 9'h0E1, -1, 0, 0, 1'b1);
      chk("R7 char after glitch", cap_data, 8'hE1);
    end

    // long break
    begin
      int pre;
      pre = cap_cnt;
      rx_line = 1'b0; ticks(12 * 16);
      chk("R8 one break char", cap_cnt, pre + 1);
      chk("R8 break data zero", cap_data, 8'h00);
      chk("R8 break framing", cap_fe, 1'b1);
      chk("R9 idle while held", rx_idle, 1'b1);
      ticks(20 * 16);
      chk("R9 no char while low", cap_cnt, pre + 1);
      rx_line = 1'b1; ticks(32);
      send_frame(0, 0, 0, 0, 9'h05A, -1, 0, 0, 1'b1);
      chk("R9 resume count", cap_cnt, pre + 2);
      chk("R9 resume data", cap_data, 8'h5A);
      chk("R9 resume no framing", cap_fe, 1'b0);
    end

    // receiver disabled
    begin
      int pre;
      pre = cap_cnt;
      rx_en = 1'b0;
      send_frame(0, 0, 0, 0, 9'h099, -1, 0, 0, 1'b0);
      chk("R11 no char when off", cap_cnt, pre);
      chk("R11 idle when off", rx_idle, 1'b1);
      rx_en = 1'b1; ticks(4);
      send_frame(0, 0, 0, 0, 9'h066, -1, 0, 0, 1'b1);
      chk("R11 char after enable", cap_data, 8'h66);
    end

    chk("R12 valid width", max_run, 1);
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule